// File: doc/BRIEF.md
# Three-Axis Sample Queue with Selectable Capture Modes

This block stores three-axis sensor readings, each axis a signed 16-bit value, so that a slower reader can collect them later. Readings arrive on a valid strobe. They go into a 32-entry circular queue. In front of the queue sits a single output holding stage, and the reader sees the oldest stored reading there. One pop strobe removes the whole three-axis reading at once. The next oldest reading then moves forward into the holding stage. Because of this extra stage, up to 33 readings can be held at one time.

A 2-bit mode field selects how the block behaves:
- In pass-through mode the queue is not used.
- In fill mode the block stops taking readings once it is full.
- In ring mode the oldest readings are replaced by new ones.
- In capture mode the block keeps a programmable number of readings from before an event. It then keeps collecting after the event until it is full.

The capture event is the rising edge of one of two interrupt inputs, picked by a select bit. A 5-bit level field sets the watermark for the fill and ring modes. In capture mode, the same field sets how many readings are kept from before the event.

Top module: `tri_axis_fifo`

## Requirements
- R1: After reset the block reports `out_valid`=0, `level`=0, `overflow`=0 and `trig_seen`=0, and it acts in pass-through mode.
- R2: Mode 2'b00 is pass-through. The queue stays empty (`level`=0). Each valid reading appears on the outputs after the next clock edge, replacing whatever was held. A pop with no new reading clears `out_valid`.
- R3: Mode 2'b01 is fill. Readings are kept in arrival order. The first reading goes to the holding stage and up to 32 more go into the queue. A reading that arrives when the holding stage and queue are both full, with no pop in the same cycle, is dropped and sets `overflow`.
- R4: Mode 2'b10 is ring. When full and not popped, a new reading discards the oldest reading, so the 33 most recent readings are kept in order. Each such overwrite sets `overflow`.
- R5: Mode 2'b11 is capture. Before the event, `out_valid` stays 0 and the queue keeps only the newest N readings, where N is `thresh`. With N=0 nothing is kept.
- R6: The event is a rising edge of `evt_a` when `trig_sel`=0, or of `evt_b` when `trig_sel`=1. Only the first edge while in capture mode counts. `trig_seen` goes to 1 after that clock edge and stays 1 until the mode changes. Outside capture mode, edges are ignored.
- R7: After the event, the kept readings move forward to the output. Collection continues until the holding stage plus 32 queue entries are full. Further readings are then dropped and set `overflow`.
- R8: `watermark` is 1 whenever `thresh`=0, in any mode. In fill and ring modes it is 1 when `level` >= `thresh`. Otherwise it is 0.
- R9: A pop while `out_valid`=1 removes all three axes of the held reading together. The next oldest reading is presented after the next edge. A pop while `out_valid`=0 has no effect.
- R10: When `mode` differs from the mode in force, the next edge empties the queue and holding stage and clears `overflow` and `trig_seen`. A reading that arrives in that cycle is discarded.
- R11: `level` counts queue entries from 0 to 32, never counting the holding stage. It is unchanged when a push and a pop happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | A new reading is present this cycle |
| smp_x | input | 16 | X axis of new reading, two's complement |
| smp_y | input | 16 | Y axis of new reading, two's complement |
| smp_z | input | 16 | Z axis of new reading, two's complement |
| mode | input | 2 | 00 pass-through, 01 fill, 10 ring, 11 capture |
| thresh | input | 5 | Watermark level, or number of pre-event readings kept |
| trig_sel | input | 1 | Event source: 0 selects evt_a, 1 selects evt_b |
| evt_a | input | 1 | First interrupt input |
| evt_b | input | 1 | Second interrupt input |
| pop | input | 1 | Remove the held reading |
| out_valid | output | 1 | Holding stage contains a reading |
| out_x | output | 16 | X axis of held reading |
| out_y | output | 16 | Y axis of held reading |
| out_z | output | 16 | Z axis of held reading |
| level | output | 6 | Number of readings in the queue |
| watermark | output | 1 | Watermark status |
| overflow | output | 1 | Sticky flag for a lost or overwritten reading |
| trig_seen | output | 1 | Capture event has occurred |

## Verification
Readings, pops and mode changes take effect at the first rising edge after they are driven. The holding stage, `level`, `overflow` and `trig_seen` all show the result right after that edge. A reading that follows a reading still queued reaches the holding stage only one edge after the pop that frees it. `watermark` is a combinational function of the registered level and the current `thresh`, so it is due in the same cycle as `level`. The bench changes inputs on falling edges and advances its reference model once per rising edge. It compares every output on the next falling edge, so each expected value is read exactly one register stage after its stimulus.

// File: rtl/taf_pkg.sv
// Shared types for the three-axis sample queue.
package taf_pkg;

    // Capture mode encoding; the order is part of the external interface.
    typedef enum logic [1:0] {
        MODE_PASS = 2'b00,
        MODE_FILL = 2'b01,
        MODE_RING = 2'b10,
        MODE_CAPT = 2'b11
    } fifo_mode_e;

endpackage

// File: rtl/taf_queue.sv
// Circular storage with head/tail pointers and an occupancy counter.
// Assumes the caller never requests enq on a full queue without a deq in
// the same cycle, and never deq on an empty queue. clr wins over both.
module taf_queue #(
    parameter int W     = 48,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         enq,
    input  logic                         deq,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;

    // Write the incoming entry at the tail.
    always_ff @(posedge clk) begin
        if (enq && !clr) mem[wr_ptr] <= din;
    end

    // Advance pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (enq) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (deq) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({enq, deq})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign level = count;
endmodule

// File: rtl/taf_trigger.sv
// Detects the first rising edge of the selected event input while armed
// and keeps a sticky flag until clr. Assumes event inputs are synchronous.
module taf_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arm,
    input  logic sel,
    input  logic evt_a,
    input  logic evt_b,
    output logic fired
);
    logic prev_a, prev_b;
    logic edge_hit;

    // Remember last event levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
        end else begin
            prev_a <= evt_a;
            prev_b <= evt_b;
        end
    end

    // Rising edge of whichever input is selected.
    always_comb edge_hit = sel ? (evt_b && !prev_b) : (evt_a && !prev_a);

    // Sticky event flag; cleared on re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          fired <= 1'b0;
        else if (arm && edge_hit)   fired <= 1'b1;
    end
endmodule

// File: rtl/tri_axis_fifo.sv
// Three-axis sample queue with a holding stage in front of a circular
// queue and four capture modes. Assumes one reading per strobe and that
// mode changes are deliberate (any change re-arms and empties the block).
module tri_axis_fifo
    import taf_pkg::*;
#(
    parameter int AXIS_W = 16,
    parameter int DEPTH  = 32,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int THR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic [AXIS_W-1:0]  smp_x,
    input  logic [AXIS_W-1:0]  smp_y,
    input  logic [AXIS_W-1:0]  smp_z,
    input  logic [1:0]         mode,
    input  logic [THR_W-1:0]   thresh,
    input  logic               trig_sel,
    input  logic               evt_a,
    input  logic               evt_b,
    input  logic               pop,
    output logic               out_valid,
    output logic [AXIS_W-1:0]  out_x,
    output logic [AXIS_W-1:0]  out_y,
    output logic [AXIS_W-1:0]  out_z,
    output logic [CNT_W-1:0]   level,
    output logic               watermark,
    output logic               overflow,
    output logic               trig_seen
);
    localparam int ENT_W = 3 * AXIS_W;
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    fifo_mode_e         mode_q;
    logic [ENT_W-1:0]   hold, din, q_head;
    logic               hold_v, ovf;
    logic               mode_chg, s_in, open;
    logic               fwd, pre, ring_ovr, deq_fwd, direct, room;
    logic               enq_fwd, drop, enq_pre, deq_pre;
    logic [CNT_W-1:0]   thr_ext;

    assign din     = {smp_x, smp_y, smp_z};
    assign thr_ext = CNT_W'(thresh);

    // Queue steering for the current cycle.
    always_comb begin
        mode_chg = (mode != mode_q);
        s_in     = smp_valid && !mode_chg;
        open     = !hold_v || pop;
        fwd      = !mode_chg && (mode_q != MODE_PASS) &&
                   (mode_q != MODE_CAPT || trig_seen);
        pre      = !mode_chg && (mode_q == MODE_CAPT) && !trig_seen;
        ring_ovr = fwd && (mode_q == MODE_RING) && s_in && hold_v && !pop &&
                   (level == FULL_LVL);
        deq_fwd  = fwd && (level != '0) && (open || ring_ovr);
        direct   = fwd && s_in && (level == '0) && open;
        room     = (level != FULL_LVL) || deq_fwd;
        enq_fwd  = fwd && s_in && !direct && room;
        drop     = fwd && s_in && !direct && !room;
        enq_pre  = pre && s_in && (thresh != '0);
        deq_pre  = enq_pre && (level >= thr_ext) && (level != '0);
    end

    taf_queue #(.W(ENT_W), .DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mode_chg),
        .enq   (enq_fwd || enq_pre),
        .deq   (deq_fwd || deq_pre),
        .din   (din),
        .head  (q_head),
        .level (level)
    );

    taf_trigger u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mode_chg),
        .arm   (!mode_chg && (mode_q == MODE_CAPT)),
        .sel   (trig_sel),
        .evt_a (evt_a),
        .evt_b (evt_b),
        .fired (trig_seen)
    );

    // Track the mode in force; a difference is a re-arm request.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_PASS;
        else        mode_q <= fifo_mode_e'(mode);
    end

    // Output holding stage.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_chg) begin
            hold_v <= 1'b0;
        end else if (mode_q == MODE_PASS) begin
            if (s_in) begin
                hold   <= din;
                hold_v <= 1'b1;
            end else if (pop) begin
                hold_v <= 1'b0;
            end
        end else if (fwd) begin
            if (deq_fwd) begin
                hold   <= q_head;
                hold_v <= 1'b1;
            end else if (direct) begin
                hold   <= din;
                hold_v <= 1'b1;
            end else if (pop) begin
                hold_v <= 1'b0;
            end
        end
    end

    // Sticky loss flag.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_chg)   ovf <= 1'b0;
        else if (drop || ring_ovr) ovf <= 1'b1;
    end

    // Status outputs.
    always_comb begin
        out_valid = hold_v;
        {out_x, out_y, out_z} = hold;
        overflow  = ovf;
        watermark = (thresh == '0) ||
                    (((mode_q == MODE_FILL) || (mode_q == MODE_RING)) &&
                     (level >= thr_ext));
    end
endmodule

// File: rtl/taf_chk.sv
// Property checker for tri_axis_fifo, attached by bind below.
module taf_chk #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6,
    parameter int THR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic [1:0]       mode,
    input logic [THR_W-1:0] thresh,
    input logic             out_valid,
    input logic [CNT_W-1:0] level,
    input logic             watermark,
    input logic             overflow,
    input logic             trig_seen
);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    // R2
    bypass_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (level == '0));

    // R11
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);

    // R11
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level > $past(level)) |-> (level == $past(level) + 1'b1));

    // R6
    trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_seen && mode == 2'b11) |=> trig_seen);

    // R6
    trig_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_seen) |-> ($past(mode) == 2'b11));

    // R3
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(smp_valid));

    // R5
    pre_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b11 && !trig_seen) |-> !out_valid);

    // R8
    wm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh == '0) |-> watermark);
endmodule

bind tri_axis_fifo taf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .mode      (mode),
    .thresh    (thresh),
    .out_valid (out_valid),
    .level     (level),
    .watermark (watermark),
    .overflow  (overflow),
    .trig_seen (trig_seen)
);

// File: tb/tri_axis_fifo_tb.sv
module tri_axis_fifo_tb;
    localparam int DEPTH = 32;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        smp_valid = 1'b0, pop = 1'b0;
    logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic [1:0]  mode = 2'b00;
    logic [4:0]  thresh = 5'd4;
    logic        trig_sel = 1'b0, evt_a = 1'b0, evt_b = 1'b0;
    logic        out_valid, watermark, overflow, trig_seen;
    logic [15:0] out_x, out_y, out_z;
    logic [5:0]  level;

    always #2 clk = ~clk;

    tri_axis_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .mode(mode), .thresh(thresh), .trig_sel(trig_sel),
        .evt_a(evt_a), .evt_b(evt_b), .pop(pop),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_z(out_z),
        .level(level), .watermark(watermark), .overflow(overflow),
        .trig_seen(trig_seen)
    );

    int    n_chk = 0, n_fail = 0;
    string tag = "R1";

    // Reference model state
    logic [1:0]  m_mode = 2'b00;
    logic [47:0] m_q[$];
    logic [47:0] m_hold = '0;
    bit          m_hv = 0, m_ovf = 0, m_trig = 0, m_pa = 0, m_pb = 0;

    task automatic chk(string t, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", t, what, act, exp);
        end
    endtask

    function automatic bit wm_exp();
        return (thresh == 0) ||
               ((m_mode == 2'b01 || m_mode == 2'b10) && m_q.size() >= int'(thresh));
    endfunction

    // Advance the model by one rising edge using the driven inputs.
    task automatic model_step();
        logic [47:0] d = {smp_x, smp_y, smp_z};
        bit edge_hit = trig_sel ? (evt_b && !m_pb) : (evt_a && !m_pa);
        bit fwd = (m_mode == 2'b01) || (m_mode == 2'b10) || (m_mode == 2'b11 && m_trig);
        if (mode != m_mode) begin
            m_q.delete(); m_hv = 0; m_ovf = 0; m_trig = 0;
        end else begin
            if (m_mode == 2'b00) begin
                if (smp_valid) begin m_hold = d; m_hv = 1; end
                else if (pop) m_hv = 0;
            end else if (fwd) begin
                if (pop && m_hv) m_hv = 0;
                if (!m_hv && m_q.size() > 0) begin m_hold = m_q.pop_front(); m_hv = 1; end
                if (smp_valid) begin
                    if (!m_hv) begin m_hold = d; m_hv = 1; end
                    else if (m_q.size() < DEPTH) m_q.push_back(d);
                    else if (m_mode == 2'b10) begin
                        m_hold = m_q.pop_front(); m_q.push_back(d); m_ovf = 1;
                    end else m_ovf = 1;
                end
            end else begin
                if (smp_valid && thresh != 0) begin
                    if (m_q.size() >= int'(thresh)) void'(m_q.pop_front());
                    m_q.push_back(d);
                end
            end
            if (m_mode == 2'b11 && !m_trig && edge_hit) m_trig = 1;
        end
        m_pa = evt_a; m_pb = evt_b; m_mode = mode;
    endtask

    task automatic compare();
        chk(tag, "out_valid", out_valid, m_hv);
        if (m_hv) chk(tag, "data", {out_x, out_y, out_z}, m_hold);
        chk(tag, "level", level, m_q.size());
        chk("R8", "watermark", watermark, wm_exp());
        chk(tag, "overflow", overflow, m_ovf);
        chk("R6", "trig_seen", trig_seen, m_trig);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic new_sample(bit v);
        smp_valid = v;
        smp_x = 16'($urandom); smp_y = 16'($urandom); smp_z = 16'($urandom);
    endtask

    task automatic push(int n);
        for (int i = 0; i < n; i++) begin new_sample(1); tick(); end
        smp_valid = 0;
    endtask

    task automatic drain(int n);
        pop = 1;
        for (int i = 0; i < n; i++) tick();
        pop = 0;
    endtask

    task automatic rnd(int n, int pv, int pp);
        for (int i = 0; i < n; i++) begin
            new_sample(($urandom % 100) < pv);
            pop = (($urandom % 100) < pp);
            tick();
        end
        smp_valid = 0; pop = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        tag = "R1"; compare();

        tag = "R2"; rnd(40, 50, 30);

        tag = "R3"; mode = 2'b01; thresh = 5'd8; tick();
        push(40);
        tag = "R9"; drain(36);
        tag = "R11"; rnd(60, 50, 50);

        tag = "R4"; mode = 2'b10; thresh = 5'd20; tick();
        push(45); drain(36);

        tag = "R5"; mode = 2'b11; thresh = 5'd5; trig_sel = 1; tick();
        push(12);
        evt_a = 1; push(3); evt_a = 0; push(3);
        tag = "R7"; evt_b = 1; push(1); push(40);
        pop = 1; push(10); pop = 0;
        evt_b = 0; push(2); evt_b = 1; push(2);
        drain(36);

        tag = "R5"; mode = 2'b00; tick(); evt_b = 0;
        mode = 2'b11; thresh = 5'd0; trig_sel = 0; tick();
        push(10); pop = 1; tick(); pop = 0;
        tag = "R7"; evt_a = 1; push(4); evt_a = 0; drain(6);

        tag = "R8"; mode = 2'b01; thresh = 5'd3; tick();
        push(5); thresh = 5'd0; tick(); thresh = 5'd6; drain(3);
        mode = 2'b00; thresh = 5'd2; push(3);

        tag = "R10"; mode = 2'b01; tick(); push(10);
        mode = 2'b10; new_sample(1); tick(); push(2); drain(3);

        tag = "R11";
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 100) == 0) begin mode = 2'($urandom); trig_sel = 1'($urandom); end
            if (($urandom % 50) == 0) thresh = 5'($urandom);
            if (($urandom % 20) == 0) evt_a = ~evt_a;
            if (($urandom % 20) == 0) evt_b = ~evt_b;
            new_sample(($urandom % 2) == 0);
            pop = (($urandom % 3) == 0);
            tick();
        end

        summary();
        $finish;
    end
endmodule